// File: doc/BRIEF.md
# Packet-Aware Shared-Storage Multi-Queue FIFO

This block is a single-clock FIFO that holds four logical queues in one shared storage array. Each queue has a fixed slice of the array, with its own read pointer, write pointer and fill count. The write side picks its target queue with a queue index. The read side picks its source queue with a second, independent index. The active-low almost-empty flag follows the queue chosen for reading. The active-low almost-full flag follows the queue chosen for writing.

The operating mode is captured while the synchronous reset is held. Packet mode is entered only when the packet request and the full-width indication are both high at that time. In packet mode each write can carry a start marker and an end marker. The active-low packet-ready flag then shows whether the queue chosen for reading holds at least one complete packet. If the writer moves to a different queue while a packet is still open in the previous one, the block raises a one-cycle protocol-error pulse.

A single-cycle low pulse on the queue-clear input empties one queue. It acts only when that queue has been chosen on both ports for at least the two preceding cycles. All other queues and the captured mode are left as they are.

Top module: `mq_pkt_fifo`

## Requirements
- R1: Words written to queue q (write index `wr_q`) are returned from queue q (read index `rd_q`) in write order. Traffic to other queues does not disturb them.
- R2: An accepted read drives `rd_valid` high in the next cycle. In that cycle `rd_data` holds the word and `rd_eop` holds the end marker that was stored with it. Otherwise `rd_valid` is low.
- R3: `almost_empty_n` is low exactly when the fill count of queue `rd_q` is at or below `AE_OFF` (default 2).
- R4: `almost_full_n` is low exactly when the free space of queue `wr_q` (`Q_DEPTH` minus its fill count, default depth 16) is at or below `AF_OFF` (default 2).
- R5: A write to a full queue is dropped and leaves that queue's contents unchanged. A read from an empty queue is dropped and produces no `rd_valid`.
- R6: `pkt_mode` equals `cfg_pkt_req AND cfg_full_width` as sampled while `rst_n` is low. After reset it does not change.
- R7: `pkt_ready_n` is low exactly when `pkt_mode` is high and queue `rd_q` holds at least one complete packet. Outside packet mode it stays high.
- R8: In packet mode, a queue's complete-packet count rises when a word with `wr_eop` set is accepted. It falls when such a word is read out.
- R9: In packet mode, `proto_err` is high for one cycle, in the cycle after an issued write whose `wr_q` differs from the previous write's queue while that previous queue holds a packet opened with `wr_sop` but not yet closed with `wr_eop`.
- R10: If `qrst_n` is low in a cycle where `wr_q == rd_q` and this same index has been on both ports for the two preceding cycles, that queue becomes empty and its packet count becomes zero. Other queues keep their contents.
- R11: A `qrst_n` pulse that does not meet the condition in R10 has no effect on any queue.
- R12: A queue clear leaves `pkt_mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous master reset, active low; the mode is sampled while it is low |
| cfg_pkt_req | input | 1 | Request for packet mode, sampled during reset |
| cfg_full_width | input | 1 | High when both ports run at full word width, sampled during reset |
| wr_en | input | 1 | Write request |
| wr_q | input | 2 | Queue index on the write port |
| wr_data | input | 32 | Write data |
| wr_sop | input | 1 | Start-of-packet marker for this write |
| wr_eop | input | 1 | End-of-packet marker for this write |
| rd_en | input | 1 | Read request |
| rd_q | input | 2 | Queue index on the read port |
| qrst_n | input | 1 | Queue-clear pulse, active low |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| rd_eop | output | 1 | End marker stored with the word being returned |
| rd_valid | output | 1 | Read result valid |
| almost_empty_n | output | 1 | Almost-empty flag of queue `rd_q`, active low |
| almost_full_n | output | 1 | Almost-full flag of queue `wr_q`, active low |
| pkt_ready_n | output | 1 | Complete packet available in queue `rd_q`, active low |
| pkt_mode | output | 1 | Captured operating mode, high for packet mode |
| proto_err | output | 1 | Queue switch with an open packet |

## Verification
A corrupted pointer or fill count shows up at the ports in the same cycle on the flags of whichever queue is selected. It shows up one cycle after the next read as a wrong word or a wrong end marker. A stale packet count is visible immediately on `pkt_ready_n` once the affected queue is chosen for reading. A queue-clear qualifier that is off by one cycle becomes visible as soon as the cleared or surviving queue is read back or its flags are selected.

// File: rtl/mqf_pkg.sv
package mqf_pkg;

    typedef enum logic {
        MODE_LEVEL  = 1'b0,
        MODE_PACKET = 1'b1
    } mqf_mode_e;

    function automatic logic [1:0] sat_inc2(input logic [1:0] v);
        return (v == 2'd2) ? 2'd2 : v + 2'd1;
    endfunction

endpackage

// File: rtl/mqf_queue.sv
module mqf_queue #(
    parameter int QDEPTH = 16,
    localparam int PW = $clog2(QDEPTH),
    localparam int CW = $clog2(QDEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic          push_sop_i,
    input  logic          push_eop_i,
    input  logic          pop_i,
    input  logic          pop_eop_i,
    output logic [PW-1:0] wptr_o,
    output logic [PW-1:0] rptr_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] pkts_o,
    output logic          open_o
);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic [CW-1:0] pkts;
        logic          open;
    } qstate_t;

    qstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (push_i) begin
                st_d.wptr = st_q.wptr + PW'(1);
                if (push_sop_i) begin
                    st_d.open = 1'b1;
                end
                if (push_eop_i) begin
                    st_d.open = 1'b0;
                    st_d.pkts = st_q.pkts + CW'(1);
                end
            end
            if (pop_i) begin
                st_d.rptr = st_q.rptr + PW'(1);
                if (pop_eop_i) begin
                    st_d.pkts = st_d.pkts - CW'(1);
                end
            end
            case ({push_i, pop_i})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr_o = st_q.wptr;
    assign rptr_o = st_q.rptr;
    assign cnt_o  = st_q.cnt;
    assign pkts_o = st_q.pkts;
    assign open_o = st_q.open;

endmodule

// File: rtl/mqf_store.sv
module mqf_store #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          wtag_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic          peek_tag_o,
    output logic [W-1:0]  rdata_o,
    output logic          rtag_o,
    output logic          rvalid_o
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         tag;
        logic         valid;
    } rdout_t;

    logic [W:0] mem_q [DEPTH];
    rdout_t     out_d, out_q;

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= {wtag_i, wdata_i};
        end
    end

    assign peek_tag_o = mem_q[raddr_i][W];

    always_comb begin
        out_d       = out_q;
        out_d.valid = re_i;
        if (re_i) begin
            out_d.data = mem_q[raddr_i][W-1:0];
            out_d.tag  = mem_q[raddr_i][W];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rdata_o  = out_q.data;
    assign rtag_o   = out_q.tag;
    assign rvalid_o = out_q.valid;

endmodule

// File: rtl/mqf_guard.sv
module mqf_guard
    import mqf_pkg::*;
#(
    parameter int QN = 4,
    localparam int QW = $clog2(QN)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          pkt_mode_i,
    input  logic          wr_en_i,
    input  logic [QW-1:0] wr_q_i,
    input  logic [QW-1:0] rd_q_i,
    input  logic          qrst_ni,
    input  logic [QN-1:0] open_i,
    output logic          take_o,
    output logic          err_o
);

    typedef struct packed {
        logic [QW-1:0] prev_sel;
        logic [1:0]    hold;
        logic [QW-1:0] last_wq;
        logic          err;
    } gstate_t;

    gstate_t st_d, st_q;
    logic    match, same;

    always_comb begin
        match  = (wr_q_i == rd_q_i);
        same   = (wr_q_i == st_q.prev_sel);
        take_o = !qrst_ni && match && same && (st_q.hold == 2'd2);

        st_d          = st_q;
        st_d.prev_sel = wr_q_i;
        if (!match) begin
            st_d.hold = 2'd0;
        end else if (same && (st_q.hold != 2'd0)) begin
            st_d.hold = sat_inc2(st_q.hold);
        end else begin
            st_d.hold = 2'd1;
        end
        st_d.err = pkt_mode_i && wr_en_i && (wr_q_i != st_q.last_wq)
                   && open_i[st_q.last_wq];
        if (wr_en_i) begin
            st_d.last_wq = wr_q_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;

endmodule

// File: rtl/mq_pkt_fifo.sv
module mq_pkt_fifo
    import mqf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_Q   = 4,
    parameter int Q_DEPTH = 16,
    parameter int AE_OFF  = 2,
    parameter int AF_OFF  = 2,
    localparam int QW = $clog2(NUM_Q),
    localparam int PW = $clog2(Q_DEPTH),
    localparam int CW = $clog2(Q_DEPTH + 1),
    localparam int AW = QW + PW,
    localparam int MEM_DEPTH = NUM_Q * Q_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pkt_req,
    input  logic              cfg_full_width,
    input  logic              wr_en,
    input  logic [QW-1:0]     wr_q,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              rd_en,
    input  logic [QW-1:0]     rd_q,
    input  logic              qrst_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eop,
    output logic              rd_valid,
    output logic              almost_empty_n,
    output logic              almost_full_n,
    output logic              pkt_ready_n,
    output logic              pkt_mode,
    output logic              proto_err
);

    mqf_mode_e mode_d, mode_q;

    logic [PW-1:0] wptr_a [NUM_Q];
    logic [PW-1:0] rptr_a [NUM_Q];
    logic [CW-1:0] cnt_a  [NUM_Q];
    logic [CW-1:0] pkts_a [NUM_Q];
    logic [NUM_Q-1:0] open_v;
    logic [NUM_Q-1:0] push_v;
    logic [NUM_Q-1:0] pop_v;
    logic [NUM_Q-1:0] clr_v;

    logic          in_pkt;
    logic          take;
    logic          wr_ok, rd_ok;
    logic          peek_tag;
    logic [AW-1:0] waddr, raddr;

    always_comb begin
        mode_d = mode_q;
        if (!rst_n) begin
            mode_d = (cfg_pkt_req && cfg_full_width) ? MODE_PACKET : MODE_LEVEL;
        end
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    assign in_pkt = (mode_q == MODE_PACKET);

    always_comb begin
        wr_ok = wr_en && (cnt_a[wr_q] != CW'(Q_DEPTH)) && !take;
        rd_ok = rd_en && (cnt_a[rd_q] != '0) && !take;
        waddr = {wr_q, wptr_a[wr_q]};
        raddr = {rd_q, rptr_a[rd_q]};
    end

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_q
        assign push_v[gi] = wr_ok && (wr_q == QW'(gi));
        assign pop_v[gi]  = rd_ok && (rd_q == QW'(gi));
        assign clr_v[gi]  = take && (wr_q == QW'(gi));

        mqf_queue #(.QDEPTH(Q_DEPTH)) u_q (
            .clk_i      (clk),
            .rst_ni     (rst_n),
            .clr_i      (clr_v[gi]),
            .push_i     (push_v[gi]),
            .push_sop_i (wr_sop && in_pkt),
            .push_eop_i (wr_eop && in_pkt),
            .pop_i      (pop_v[gi]),
            .pop_eop_i  (peek_tag && in_pkt),
            .wptr_o     (wptr_a[gi]),
            .rptr_o     (rptr_a[gi]),
            .cnt_o      (cnt_a[gi]),
            .pkts_o     (pkts_a[gi]),
            .open_o     (open_v[gi])
        );
    end

    mqf_store #(.W(DATA_W), .DEPTH(MEM_DEPTH)) u_store (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .we_i       (wr_ok),
        .waddr_i    (waddr),
        .wdata_i    (wr_data),
        .wtag_i     (wr_eop),
        .re_i       (rd_ok),
        .raddr_i    (raddr),
        .peek_tag_o (peek_tag),
        .rdata_o    (rd_data),
        .rtag_o     (rd_eop),
        .rvalid_o   (rd_valid)
    );

    mqf_guard #(.QN(NUM_Q)) u_guard (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pkt_mode_i (in_pkt),
        .wr_en_i    (wr_en),
        .wr_q_i     (wr_q),
        .rd_q_i     (rd_q),
        .qrst_ni    (qrst_n),
        .open_i     (open_v),
        .take_o     (take),
        .err_o      (proto_err)
    );

    always_comb begin
        almost_empty_n = !(int'(cnt_a[rd_q]) <= AE_OFF);
        almost_full_n  = !((Q_DEPTH - int'(cnt_a[wr_q])) <= AF_OFF);
        pkt_ready_n    = !(in_pkt && (pkts_a[rd_q] != '0));
        pkt_mode       = in_pkt;
    end

endmodule

// File: rtl/mqf_chk.sv
module mqf_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic rd_en_i,
    input logic wr_en_i,
    input logic rd_valid_i,
    input logic pkt_mode_i,
    input logic pkt_ready_ni,
    input logic proto_err_i
);

    AST_RD_VALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_i |-> $past(rd_en_i)); // R2

    AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> $stable(pkt_mode_i)); // R6

    AST_READY_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pkt_ready_ni |-> pkt_mode_i); // R7

    AST_ERR_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        proto_err_i |-> pkt_mode_i); // R9

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        proto_err_i |-> $past(wr_en_i)); // R9

endmodule

bind mq_pkt_fifo mqf_chk u_chk (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rd_en_i      (rd_en),
    .wr_en_i      (wr_en),
    .rd_valid_i   (rd_valid),
    .pkt_mode_i   (pkt_mode),
    .pkt_ready_ni (pkt_ready_n),
    .proto_err_i  (proto_err)
);

// File: tb/sim_mq_pkt_fifo.sv
module sim_mq_pkt_fifo;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pkt_req = 1'b0;
    logic        cfg_full_width = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_q = 2'd0;
    logic [31:0] wr_data = '0;
    logic        wr_sop = 1'b0;
    logic        wr_eop = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_q = 2'd0;
    logic        qrst_n = 1'b1;
    logic [31:0] rd_data;
    logic        rd_eop, rd_valid, almost_empty_n, almost_full_n;
    logic        pkt_ready_n, pkt_mode, proto_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mq_pkt_fifo u0 (.*);

    // {is_read, queue, data written or data expected}
    localparam logic [34:0] VEC [10] = '{
        {1'b0, 2'd0, 32'h0000_00A0},
        {1'b0, 2'd1, 32'h0000_00B0},
        {1'b0, 2'd2, 32'h0000_00C0},
        {1'b0, 2'd0, 32'h0000_00A1},
        {1'b1, 2'd1, 32'h0000_00B0},
        {1'b0, 2'd3, 32'h0000_00D0},
        {1'b1, 2'd0, 32'h0000_00A0},
        {1'b1, 2'd2, 32'h0000_00C0},
        {1'b1, 2'd0, 32'h0000_00A1},
        {1'b1, 2'd3, 32'h0000_00D0}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic req, input logic fw);
        rst_n = 1'b0;
        cfg_pkt_req = req;
        cfg_full_width = fw;
        repeat (3) tick();
        rst_n = 1'b1;
        cfg_pkt_req = 1'b0;
        cfg_full_width = 1'b0;
        tick();
    endtask

    task automatic wr(input logic [1:0] q, input logic [31:0] d,
                      input logic sop, input logic eop);
        wr_en = 1'b1; wr_q = q; wr_data = d; wr_sop = sop; wr_eop = eop;
        tick();
        wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    endtask

    task automatic rd(input logic [1:0] q);
        rd_en = 1'b1; rd_q = q;
        tick();
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // level mode reset
        do_reset(1'b0, 1'b1);
        chk("R6", "mode after level reset", 64'(pkt_mode), 64'd0);
        chk("R3", "empty queue almost-empty", 64'(almost_empty_n), 64'd0);
        chk("R4", "empty queue almost-full", 64'(almost_full_n), 64'd1);
        chk("R7", "ready in level mode", 64'(pkt_ready_n), 64'd1);
        chk("R2", "no valid after reset", 64'(rd_valid), 64'd0);

        // vector table: interleaved queues (R1, R2)
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][34]) begin
                rd(VEC[i][33:32]);
                chk("R2", "read valid", 64'(rd_valid), 64'd1);
                chk("R1", "queue order", 64'(rd_data), 64'(VEC[i][31:0]));
            end else begin
                wr(VEC[i][33:32], VEC[i][31:0], 1'b0, 1'b0);
            end
        end

        // end marker in level mode: no packet-ready (R7), marker passes through (R2)
        wr(2'd1, 32'h0000_0E01, 1'b0, 1'b1);
        rd_q = 2'd1;
        tick();
        chk("R7", "no ready outside packet mode", 64'(pkt_ready_n), 64'd1);
        rd(2'd1);
        chk("R2", "end marker returned", 64'(rd_eop), 64'd1);

        // fill queue 0 (R4), overflow (R5), drain (R3), underflow (R5)
        for (int i = 0; i < 16; i++) begin
            wr(2'd0, 32'h100 + 32'(i), 1'b0, 1'b0);
            chk("R4", "almost-full while filling", 64'(almost_full_n),
                64'((16 - (i + 1)) > 2));
        end
        wr(2'd0, 32'h0000_01FF, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            rd(2'd0);
            chk("R5", "data after dropped write", 64'(rd_data), 64'(32'h100 + 32'(i)));
            chk("R3", "almost-empty while draining", 64'(almost_empty_n),
                64'((15 - i) > 2));
        end
        rd(2'd0);
        chk("R5", "read of empty queue dropped", 64'(rd_valid), 64'd0);

        // packet request without full width stays in level mode (R6)
        do_reset(1'b1, 1'b0);
        chk("R6", "packet request refused", 64'(pkt_mode), 64'd0);
        do_reset(1'b1, 1'b1);
        chk("R6", "packet mode entered", 64'(pkt_mode), 64'd1);

        // packet tracking (R7, R8)
        rd_q = 2'd1;
        wr(2'd1, 32'h0000_0A01, 1'b1, 1'b0);
        wr(2'd1, 32'h0000_0A02, 1'b0, 1'b0);
        chk("R7", "open packet not ready", 64'(pkt_ready_n), 64'd1);
        wr(2'd1, 32'h0000_0A03, 1'b0, 1'b1);
        chk("R7", "complete packet ready", 64'(pkt_ready_n), 64'd0);
        rd_q = 2'd2;
        tick();
        chk("R7", "other queue not ready", 64'(pkt_ready_n), 64'd1);
        wr(2'd1, 32'h0000_0B01, 1'b1, 1'b0);
        wr(2'd1, 32'h0000_0B02, 1'b0, 1'b1);
        rd(2'd1);
        rd(2'd1);
        rd(2'd1);
        chk("R8", "first packet end read", 64'(rd_eop), 64'd1);
        chk("R8", "second packet still ready", 64'(pkt_ready_n), 64'd0);
        rd(2'd1);
        rd(2'd1);
        chk("R8", "last packet read out", 64'(pkt_ready_n), 64'd1);

        // protocol error on switch with open packet (R9)
        wr(2'd2, 32'h0000_0020, 1'b1, 1'b0);
        chk("R9", "no error inside packet", 64'(proto_err), 64'd0);
        wr(2'd3, 32'h0000_0030, 1'b0, 1'b0);
        chk("R9", "switch with open packet", 64'(proto_err), 64'd1);
        wr(2'd2, 32'h0000_0021, 1'b0, 1'b1);
        chk("R9", "switch from closed queue", 64'(proto_err), 64'd0);

        // queue clear without the selection history is ignored (R11)
        wr_q = 2'd2; rd_q = 2'd2; qrst_n = 1'b0;
        tick();
        qrst_n = 1'b1;
        chk("R11", "fresh selection clear ignored", 64'(pkt_ready_n), 64'd0);
        wr_q = 2'd2; rd_q = 2'd3;
        repeat (3) tick();
        qrst_n = 1'b0;
        tick();
        qrst_n = 1'b1;
        rd_q = 2'd2;
        tick();
        chk("R11", "mismatched clear ignored", 64'(pkt_ready_n), 64'd0);

        // qualified clear of queue 2 (R10, R12)
        tick();
        tick();
        qrst_n = 1'b0;
        tick();
        qrst_n = 1'b1;
        chk("R10", "cleared queue not ready", 64'(pkt_ready_n), 64'd1);
        chk("R10", "cleared queue almost-empty", 64'(almost_empty_n), 64'd0);
        chk("R12", "mode kept after clear", 64'(pkt_mode), 64'd1);
        rd(2'd2);
        chk("R10", "cleared queue yields nothing", 64'(rd_valid), 64'd0);
        rd(2'd3);
        chk("R10", "other queue kept", 64'(rd_data), 64'h30);
        wr(2'd2, 32'h0000_0055, 1'b0, 1'b0);
        rd(2'd2);
        chk("R10", "cleared queue reusable", 64'(rd_data), 64'h55);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule